// File: doc/BRIEF.md
# Register-Mapped Serial Port with Single-Byte Buffers

This block is a small asynchronous serial port that a host drives through three 32-bit word registers on a plain read/write bus. The bus has an address, write data, a write strobe and combinational read data. The data word carries a byte in each direction and two handshake flags. One flag tells the host that the transmitter can take a new byte. The other tells the host that a received byte is waiting. Software launches a transfer by writing a byte with the transmit flag set. It releases a received byte by writing the receive flag.

The transmitter and the receiver each hold one byte. Both take their bit timing from an external oversampling strobe (`baud_tick`), which a separate baud generator produces. That generator is set up from the clock word, which this block only stores and drives out. The control word holds a two-bit line-interface mode and two ready-override bits. These are driven out to the neighbouring pin and handshake logic.

The transmit serializer has four states: TX_IDLE, TX_START, TX_DATA and TX_STOP. A launch moves it from TX_IDLE to TX_START. After 16 ticks it enters TX_DATA. It stays in TX_DATA for eight bit periods and then moves to TX_STOP. After one more bit period it returns to TX_IDLE.

The receive deserializer also has four states: RX_IDLE, RX_START, RX_DATA and RX_STOP. A low line seen on a tick moves it from RX_IDLE to RX_START. At mid-bit it goes on to RX_DATA if the line is still low, and falls back to RX_IDLE if the line is high. It moves from RX_DATA to RX_STOP after eight mid-bit samples. From RX_STOP it returns to RX_IDLE at the stop-bit sample, and it hands the byte over only if the stop bit is high.

Top module: `uart_mm_top`

## Requirements
- R1: The data word is at byte address 0x00, the control word at 0x04 and the clock word at 0x08. A read of any other address returns zero, and a write to it changes nothing.
- R2: After reset the data word reads 0x0000_0200 (transmit flag 1, receive flag 0, byte 0), the control and clock words read zero, and `ser_txd` is high.
- R3: A write to the data word with bit 9 set while bit 9 reads 1 sends wdata[7:0] as one frame. The frame is a low start bit, eight data bits LSB first and a high stop bit, each lasting 16 `baud_tick` strobes. Bit 9 reads 0 from the cycle after the write until the stop bit ends, and then reads 1 again.
- R4: A data-word write with bit 9 clear starts no frame. A data-word write with bit 9 set while a frame is in progress is ignored, and the frame in flight is not altered.
- R5: A frame received on `ser_rxd` whose stop bit samples high puts its byte in data bits [7:0] and sets bit 8 (the receive flag).
- R6: A start edge whose line is no longer low at mid-bit (the 8th tick) is discarded, and the receive flag stays clear.
- R7: A frame whose stop bit samples low is discarded, and the receive flag stays clear.
- R8: A byte that completes while the receive flag is set is dropped. The held byte and the flag are kept.
- R9: A data-word write with bit 8 set clears the receive flag. If a byte completes in that same cycle, that byte is kept and the flag stays set. A single write may both clear the flag and launch a frame.
- R10: In the control word, bits [3:2] are the interface mode (1 = DTE, 2 = DCE), bit 7 is the transmit-ready override and bit 8 is the receive-ready override. All other bits read 0. These fields drive `if_mode`, `tx_rdy_ovr` and `rx_rdy_ovr`.
- R11: The clock word is a 32-bit read/write register whose value is driven on `clk_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ser_rxd | input | 1 | Serial input line |
| ser_txd | output | 1 | Serial output line, idle high |
| if_mode | output | 2 | Interface mode field of the control word |
| tx_rdy_ovr | output | 1 | Transmit-ready override bit |
| rx_rdy_ovr | output | 1 | Receive-ready override bit |
| clk_cfg | output | 32 | Clock word for the baud generator |

## Verification
Releasing a received byte and launching a new transmit byte can fall on the same bus write, because both flags live in the same data word. The bench first leaves a byte waiting. It then writes the data word once with bits 9 and 8 both set. It judges the result by reading the data word right after the write: the receive flag must be clear and the transmit flag must be busy. The frame that follows must carry the new byte. The other same-cycle case is an acknowledge that lands in the cycle where a new byte completes. The checker covers it through the rule on held-byte stability and flag clearing.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_STOP
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    // Byte offsets of the three words
    localparam int unsigned OFS_DATA = 0;
    localparam int unsigned OFS_CTRL = 4;
    localparam int unsigned OFS_CLK  = 8;

    // Data word flag positions
    localparam int unsigned RXF_BIT = 8;
    localparam int unsigned TXF_BIT = 9;

    // Control word field positions
    localparam int unsigned MODE_LO   = 2;
    localparam int unsigned TXOVR_BIT = 7;
    localparam int unsigned RXOVR_BIT = 8;

endpackage

// File: rtl/uart_mm_tx.sv
module uart_mm_tx
    import uart_mm_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] load_byte,
    output logic                 ready,
    output logic                 txd
);
    localparam int unsigned CW = $clog2(OVS);
    localparam int unsigned IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

    tx_state_t            state_q, state_d;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic [IW-1:0]        idx_q, idx_d;
    logic [DATA_BITS-1:0] sh_q, sh_d;
    logic                 bit_end;

    assign bit_end = tick && (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        if (state_q != TX_IDLE && tick) begin
            cnt_d = bit_end ? '0 : cnt_q + 1'b1;
        end
        unique case (state_q)
            TX_IDLE: begin
                if (load) begin
                    state_d = TX_START;
                    cnt_d   = '0;
                    idx_d   = '0;
                    sh_d    = load_byte;
                end
            end
            TX_START: begin
                if (bit_end) state_d = TX_DATA;
            end
            TX_DATA: begin
                if (bit_end) begin
                    sh_d  = sh_q >> 1;
                    idx_d = idx_q + 1'b1;
                    if (idx_q == IDX_LAST) state_d = TX_STOP;
                end
            end
            TX_STOP: begin
                if (bit_end) state_d = TX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        ready = 1'b0;
        txd   = 1'b1;
        unique case (state_q)
            TX_IDLE:  ready = 1'b1;
            TX_START: txd   = 1'b0;
            TX_DATA:  txd   = sh_q[0];
            TX_STOP:  txd   = 1'b1;
        endcase
    end

endmodule

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
    import uart_mm_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OVS       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rxd_async,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_o
);
    localparam int unsigned CW = $clog2(OVS);
    localparam int unsigned IW = $clog2(DATA_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
    localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(DATA_BITS - 1);

    logic [1:0]           sync_q;
    logic                 rxd_s;
    rx_state_t            state_q, state_d;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic [IW-1:0]        idx_q, idx_d;
    logic [DATA_BITS-1:0] sh_q, sh_d;
    logic                 bit_end;

    assign rxd_s   = sync_q[1];
    assign bit_end = tick && (cnt_q == CNT_LAST);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        idx_d   = idx_q;
        sh_d    = sh_q;
        unique case (state_q)
            RX_IDLE: begin
                if (tick && !rxd_s) begin
                    state_d = RX_START;
                    cnt_d   = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (cnt_q == CNT_MID) begin
                        state_d = rxd_s ? RX_IDLE : RX_DATA;
                        cnt_d   = '0;
                        idx_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) cnt_d = bit_end ? '0 : cnt_q + 1'b1;
                if (bit_end) begin
                    sh_d  = {rxd_s, sh_q[DATA_BITS-1:1]};
                    idx_d = idx_q + 1'b1;
                    if (idx_q == IDX_LAST) state_d = RX_STOP;
                end
            end
            RX_STOP: begin
                if (tick) cnt_d = bit_end ? '0 : cnt_q + 1'b1;
                if (bit_end) state_d = RX_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 2'b11;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            sh_q    <= '0;
        end else begin
            sync_q  <= {sync_q[0], rxd_async};
            state_q <= state_d;
            cnt_q   <= cnt_d;
            idx_q   <= idx_d;
            sh_q    <= sh_d;
        end
    end

    always_comb begin
        done   = 1'b0;
        byte_o = sh_q;
        unique case (state_q)
            RX_IDLE, RX_START, RX_DATA: done = 1'b0;
            RX_STOP: done = bit_end && rxd_s;
        endcase
    end

endmodule

// File: rtl/uart_mm_regs.sv
module uart_mm_regs
    import uart_mm_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic                 tx_ready,
    output logic                 tx_load,
    input  logic                 rx_done,
    input  logic [DATA_BITS-1:0] rx_byte,
    output logic                 rx_flag,
    output logic [DATA_BITS-1:0] rx_hold,
    output logic [1:0]           mode,
    output logic                 txovr,
    output logic                 rxovr,
    output logic [31:0]          clk_word
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(OFS_CLK);

    logic wr_data, wr_ctrl, wr_clk, rx_ack;

    assign wr_data = bus_wr && (bus_addr == A_DATA);
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_clk  = bus_wr && (bus_addr == A_CLK);
    assign tx_load = wr_data && bus_wdata[TXF_BIT] && tx_ready;
    assign rx_ack  = wr_data && bus_wdata[RXF_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flag  <= 1'b0;
            rx_hold  <= '0;
            mode     <= 2'b00;
            txovr    <= 1'b0;
            rxovr    <= 1'b0;
            clk_word <= '0;
        end else begin
            if (rx_done && (!rx_flag || rx_ack)) begin
                rx_hold <= rx_byte;
                rx_flag <= 1'b1;
            end else if (rx_ack) begin
                rx_flag <= 1'b0;
            end
            if (wr_ctrl) begin
                mode  <= bus_wdata[MODE_LO+1:MODE_LO];
                txovr <= bus_wdata[TXOVR_BIT];
                rxovr <= bus_wdata[RXOVR_BIT];
            end
            if (wr_clk) clk_word <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_DATA) begin
            bus_rdata[DATA_BITS-1:0] = rx_hold;
            bus_rdata[RXF_BIT]       = rx_flag;
            bus_rdata[TXF_BIT]       = tx_ready;
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[MODE_LO+1:MODE_LO] = mode;
            bus_rdata[TXOVR_BIT]         = txovr;
            bus_rdata[RXOVR_BIT]         = rxovr;
        end else if (bus_addr == A_CLK) begin
            bus_rdata = clk_word;
        end
    end

endmodule

// File: rtl/uart_mm_top.sv
module uart_mm_top #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned OVS       = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ser_rxd,
    output logic              ser_txd,
    output logic [1:0]        if_mode,
    output logic              tx_rdy_ovr,
    output logic              rx_rdy_ovr,
    output logic [31:0]       clk_cfg
);
    logic                 tx_ready, tx_load;
    logic                 rx_done, rx_flag;
    logic [DATA_BITS-1:0] rx_byte, rx_hold;

    uart_mm_tx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .load      (tx_load),
        .load_byte (bus_wdata[DATA_BITS-1:0]),
        .ready     (tx_ready),
        .txd       (ser_txd)
    );

    uart_mm_rx #(.DATA_BITS(DATA_BITS), .OVS(OVS)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (baud_tick),
        .rxd_async (ser_rxd),
        .done      (rx_done),
        .byte_o    (rx_byte)
    );

    uart_mm_regs #(.ADDR_W(ADDR_W), .DATA_BITS(DATA_BITS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .tx_ready  (tx_ready),
        .tx_load   (tx_load),
        .rx_done   (rx_done),
        .rx_byte   (rx_byte),
        .rx_flag   (rx_flag),
        .rx_hold   (rx_hold),
        .mode      (if_mode),
        .txovr     (tx_rdy_ovr),
        .rxovr     (rx_rdy_ovr),
        .clk_word  (clk_cfg)
    );

endmodule

// File: rtl/uart_mm_chk.sv
module uart_mm_chk #(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [1:0]           wr_flags,
    input logic [31:0]          bus_rdata,
    input logic                 ser_txd,
    input logic                 tx_ready,
    input logic                 rx_flag,
    input logic                 rx_done,
    input logic [DATA_BITS-1:0] rx_hold
);
    logic data_wr, launch, ack;

    assign data_wr = bus_wr && (bus_addr == '0);
    assign launch  = data_wr && wr_flags[1];
    assign ack     = data_wr && wr_flags[0];

    assert_idle_line_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> ser_txd);

    assert_launch_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (launch && tx_ready) |=> !tx_ready);

    assert_no_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && !launch) |=> tx_ready);

    assert_hold_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flag && rx_done && !ack) |=> (rx_flag && $stable(rx_hold)));

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !rx_done) |=> !rx_flag);

    assert_ack_and_arrival_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && rx_done) |=> rx_flag);

    assert_ctrl_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(4)) |-> ((bus_rdata & ~32'h0000_018C) == 32'h0));

endmodule

bind uart_mm_top uart_mm_chk #(.ADDR_W(ADDR_W), .DATA_BITS(DATA_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .wr_flags  (bus_wdata[9:8]),
    .bus_rdata (bus_rdata),
    .ser_txd   (ser_txd),
    .tx_ready  (tx_ready),
    .rx_flag   (rx_flag),
    .rx_done   (rx_done),
    .rx_hold   (rx_hold)
);

// File: tb/uart_mm_top_tb.sv
`timescale 1ns/1ps
module uart_mm_top_tb;
    localparam int TICK_DIV = 4;
    localparam int BITC     = 16 * TICK_DIV;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        baud_tick = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_rxd = 1'b1;
    logic        ser_txd;
    logic [1:0]  if_mode;
    logic        tx_rdy_ovr, rx_rdy_ovr;
    logic [31:0] clk_cfg;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    uart_mm_top u_dut (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .ser_rxd(ser_rxd), .ser_txd(ser_txd),
        .if_mode(if_mode), .tx_rdy_ovr(tx_rdy_ovr), .rx_rdy_ovr(rx_rdy_ovr),
        .clk_cfg(clk_cfg)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            for (int i = 0; i < TICK_DIV; i++) begin
                @(negedge clk);
                baud_tick = (i == TICK_DIV - 1);
            end
        end
    end

    function automatic logic [31:0] exp_data(input bit txf, input bit rxf, input logic [7:0] b);
        return {22'b0, txf, rxf, b};
    endfunction

    function automatic logic [31:0] exp_ctrl(input logic [31:0] w);
        return w & 32'h0000_018C;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rx_send(input logic [7:0] b, input bit good_stop);
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (BITC) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rxd = b[i];
            repeat (BITC) @(negedge clk);
        end
        if (good_stop) begin
            ser_rxd = 1'b1;
            repeat (BITC) @(negedge clk);
        end else begin
            ser_rxd = 1'b0;
            repeat (BITC * 3 / 4) @(negedge clk);
            ser_rxd = 1'b1;
            repeat (BITC) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic tx_capture(output logic [7:0] b, output logic [1:0] frame);
        int waited = 0;
        b = '0;
        frame = 2'b00;
        while (ser_txd !== 1'b0 && waited < 4000) begin
            @(negedge clk);
            waited++;
        end
        repeat (BITC / 2) @(negedge clk);
        frame[0] = ser_txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = ser_txd;
        end
        repeat (BITC) @(negedge clk);
        frame[1] = ser_txd;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  b, a2, got;
        logic [1:0]  fr;
        void'($urandom(32'd20240607));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        rd(4'h0, r); check("R2 data", r, exp_data(1, 0, 8'h00));
        rd(4'h4, r); check("R2 ctrl", r, 32'h0);
        rd(4'h8, r); check("R2 clk", r, 32'h0);
        check("R2 txd", {31'b0, ser_txd}, 32'h1);

        // R1 unmapped address
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, r); check("R1 unmapped", r, 32'h0);
        rd(4'h4, r); check("R1 unmapped write", r, 32'h0);

        // R10 control word
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, r); check("R10 ctrl all", r, exp_ctrl(32'hFFFF_FFFF));
        check("R10 outs", {28'b0, if_mode, tx_rdy_ovr, rx_rdy_ovr}, 32'hF);
        wr(4'h4, 32'h0000_0088);
        rd(4'h4, r); check("R10 ctrl dce", r, 32'h88);
        check("R10 outs dce", {28'b0, if_mode, tx_rdy_ovr, rx_rdy_ovr}, 32'h0A);

        // R11 clock word
        for (int k = 0; k < 3; k++) begin
            logic [31:0] v = $urandom;
            wr(4'h8, v);
            rd(4'h8, r); check("R11 readback", r, v);
            check("R11 clk_cfg", clk_cfg, v);
        end

        // R4 write without the transmit flag
        wr(4'h0, 32'h0000_00A5);
        for (int k = 0; k < 10; k++) begin
            repeat (20) @(negedge clk);
            if (ser_txd !== 1'b1) check("R4 no frame", {31'b0, ser_txd}, 32'h1);
        end
        rd(4'h0, r); check("R4 still ready", r, exp_data(1, 0, 8'h00));

        // R3 and R4 random transmit bytes, with an ignored busy write
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            wr(4'h0, 32'h200 | b);
            rd(4'h0, r); check("R3 busy flag", r, exp_data(0, 0, 8'h00));
            wr(4'h0, 32'h200 | ~b);
            tx_capture(got, fr);
            check("R3 byte", {24'b0, got}, {24'b0, b});
            check("R3 start/stop", {30'b0, fr}, 32'h2);
            repeat (BITC) @(negedge clk);
            rd(4'h0, r); check("R3 ready after stop", r, exp_data(1, 0, 8'h00));
            repeat (BITC * 3) @(negedge clk);
            check("R4 no second frame", {31'b0, ser_txd}, 32'h1);
        end

        // R5 random receive bytes
        for (int k = 0; k < 4; k++) begin
            b = 8'($urandom);
            rx_send(b, 1'b1);
            rd(4'h0, r); check("R5 received", r, exp_data(1, 1, b));
            wr(4'h0, 32'h100);
            rd(4'h0, r); check("R9 ack clears", r[9:8], 32'h2);
        end

        // R8 overrun drops the second byte
        a2 = 8'h3C;
        rx_send(a2, 1'b1);
        rx_send(8'hC3, 1'b1);
        rd(4'h0, r); check("R8 held byte kept", r, exp_data(1, 1, a2));
        wr(4'h0, 32'h100);

        // R6 short start pulse
        @(negedge clk);
        ser_rxd = 1'b0;
        repeat (16) @(negedge clk);
        ser_rxd = 1'b1;
        repeat (BITC * 11) @(negedge clk);
        rd(4'h0, r); check("R6 glitch rejected", r[8], 32'h0);

        // R7 low stop bit
        rx_send(8'h5A, 1'b0);
        repeat (BITC * 11) @(negedge clk);
        rd(4'h0, r); check("R7 framing drop", r[8], 32'h0);

        // R9 acknowledge and launch in one write
        rx_send(8'h81, 1'b1);
        rd(4'h0, r); check("R9 byte waiting", r, exp_data(1, 1, 8'h81));
        b = 8'($urandom);
        wr(4'h0, 32'h300 | b);
        rd(4'h0, r); check("R9 combined write flags", r[9:8], 32'h0);
        tx_capture(got, fr);
        check("R9 combined write byte", {24'b0, got}, {24'b0, b});
        repeat (BITC) @(negedge clk);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule